// File: doc/BRIEF.md
# Sample Format Unpacker

This block sits between a 32-bit input data stream and a processing core that works on 16-bit native samples. Each accepted 32-bit word is split into samples of a packed width chosen by a 4-bit format code. Every sample is converted to a signed 16-bit value and handed downstream one per valid/ready handshake. In complex mode the samples alternate between in-phase and quadrature parts, and a flag marks the quadrature part.

The control word comes from a register outside this block. Its bit 0 enables processing. Its bit 1 is the direction flag: clear means acquisition, set means playback. Bits [11:8] hold the input-side format code and bits [15:12] hold the output-side format code. The direction flag picks which of the two codes describes the words arriving here. The format and direction are captured together with each word, so a register write never disturbs a word that is already being unpacked.

Top module: `sample_unpacker`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, out_valid is 0 and no word is held.
- R2: With ctrl_word bit 1 clear, the format code is read from ctrl_word[11:8]. With it set, the code is read from ctrl_word[15:12]. out_dir reports the bit 1 value captured with the word being unpacked.
- R3: Format code bits [2:0] select the sample width and the number of samples per word: 0 gives 16 bits (2 samples), 1 gives 8 bits (4), 2 gives 4 bits (8), 3 gives 1 bit (32), and 4 gives 32 bits (1). The reserved codes 5, 6 and 7 behave as 16 bits.
- R4: Samples leave in order of rising bit position. Sample k of width w is taken from bits [k*w+w-1 : k*w] of the word.
- R5: An 8-bit sample is output as {s,8'h00} and a 4-bit sample as {s,12'h000}, which keeps its sign.
- R6: A 1-bit sample of value 1 is output as 16'h7FFF and a 1-bit sample of value 0 as 16'h8001.
- R7: A 32-bit sample is output as its upper 16 bits, word[31:16].
- R8: Format code bit 3 set means complex. out_is_q is 0 for the first sample after enable or after a real word, then toggles with each emitted sample, and the I/Q pairing may span words. In real mode out_is_q is always 0.
- R9: While ctrl_word bit 0 is 0, in_ready and out_valid are 0. Any held word is discarded and the I/Q phase returns to I.
- R10: While out_valid is 1 and out_ready is 0, out_sample and out_is_q stay stable and in_ready is 0. in_ready is 1 in the cycle in which the last sample of the held word is taken, so words can be accepted back to back.
- R11: A change of the format code after a word has been accepted does not change how that word is unpacked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_word | input | 32 | Control register value: enable, direction, two format codes |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when both valid and ready are 1 |
| in_data | input | 32 | Packed input word |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the sample when both valid and ready are 1 |
| out_sample | output | 16 | Native signed sample |
| out_is_q | output | 1 | 1 when the sample is the quadrature part of a complex pair |
| out_dir | output | 1 | Direction flag captured with the current word |

## Verification
The hardest state to reach from the ports is a word that is partly unpacked at the moment the control word changes. This covers a mid-word format change, a mid-pair disable, and a complex phase that must carry across a word boundary. The bench reaches it by holding out_ready low after an accept, or releasing it for exactly one cycle, so the word stays parked at a known sample index. It then rewrites ctrl_word or clears the enable before draining. For the 1-sample 32-bit complex format, the bench feeds consecutive words to show that the I/Q flag alternates across words rather than within one.

// File: rtl/su_pkg.sv
package su_pkg;
  localparam int WORD_W  = 32;
  localparam int NAT_W   = 16;
  localparam int CTRL_W  = 32;
  localparam int CODE_W  = 4;
  localparam int IDX_W   = $clog2(WORD_W);
  localparam int EN_BIT  = 0;
  localparam int DIR_BIT = 1;
  localparam int ACQ_LSB = 8;
  localparam int PLY_LSB = 12;

  typedef enum logic [2:0] {WID16, WID8, WID4, WID1, WID32} wid_e;

  function automatic wid_e su_width(input logic [2:0] code);
    case (code)
      3'd1:    return WID8;
      3'd2:    return WID4;
      3'd3:    return WID1;
      3'd4:    return WID32;
      default: return WID16;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] su_last_index(input wid_e w);
    case (w)
      WID8:    return IDX_W'(WORD_W/8 - 1);
      WID4:    return IDX_W'(WORD_W/4 - 1);
      WID1:    return IDX_W'(WORD_W - 1);
      WID32:   return '0;
      default: return IDX_W'(WORD_W/16 - 1);
    endcase
  endfunction

  function automatic logic [2:0] su_log2w(input wid_e w);
    case (w)
      WID8:    return 3'd3;
      WID4:    return 3'd2;
      WID16:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/su_fmt_decode.sv
module su_fmt_decode
  import su_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_word,
  output wid_e              fmt_wid,
  output logic              fmt_cplx
);
  logic [CODE_W-1:0] code;

  always_comb begin
    if (ctrl_word[DIR_BIT]) code = ctrl_word[PLY_LSB +: CODE_W];
    else                    code = ctrl_word[ACQ_LSB +: CODE_W];
    fmt_wid  = su_width(code[2:0]);
    fmt_cplx = code[3];
  end
endmodule

// File: rtl/su_extract.sv
module su_extract
  import su_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  wid_e              wid,
  output logic [NAT_W-1:0]  sample
);
  logic [IDX_W-1:0]  shamt;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shamt   = idx << su_log2w(wid);
    shifted = word >> shamt;
    case (wid)
      WID8:    sample = {shifted[7:0], 8'h00};
      WID4:    sample = {shifted[3:0], 12'h000};
      WID1:    sample = shifted[0] ? 16'h7FFF : 16'h8001;
      WID32:   sample = word[WORD_W-1 -: NAT_W];
      default: sample = shifted[NAT_W-1:0];
    endcase
  end

  // R6: single-bit samples only ever map to the two full-scale codes
  always_comb begin
    if (wid == WID1) begin
      a_r6_full_scale: assert (sample == 16'h7FFF || sample == 16'h8001);
    end
  end
endmodule

// File: rtl/sample_unpacker.sv
module sample_unpacker
  import su_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NAT_W-1:0]  out_sample,
  output logic              out_is_q,
  output logic              out_dir
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic en;
  assign en = ctrl_word[EN_BIT];

  wid_e new_wid;
  logic new_cplx;
  su_fmt_decode u_dec (.ctrl_word(ctrl_word), .fmt_wid(new_wid), .fmt_cplx(new_cplx));

  // held word and its captured format
  logic [WORD_W-1:0] word_q;
  wid_e              wid_q;
  logic              cplx_q, dir_q;
  // progress state
  logic              full_q, full_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              iq_q, iq_d;

  logic at_last, out_fire, in_fire, load;

  always_comb begin
    at_last   = (idx_q == su_last_index(wid_q));
    out_valid = en && full_q;
    out_fire  = out_valid && out_ready;
    in_ready  = en && srst_n && (!full_q || (out_fire && at_last));
    in_fire   = in_valid && in_ready;
    load      = in_fire;
  end

  always_comb begin
    full_d = full_q;
    idx_d  = idx_q;
    iq_d   = iq_q;
    if (!en) begin
      full_d = 1'b0;
      idx_d  = '0;
      iq_d   = 1'b0;
    end else begin
      if (out_fire) begin
        iq_d = cplx_q & ~iq_q;
        if (at_last) begin
          full_d = 1'b0;
          idx_d  = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      if (in_fire) begin
        full_d = 1'b1;
        idx_d  = '0;
        if (!new_cplx) iq_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      iq_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      idx_q  <= idx_d;
      iq_q   <= iq_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      word_q <= '0;
      wid_q  <= WID16;
      cplx_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (load) begin
      word_q <= in_data;
      wid_q  <= new_wid;
      cplx_q <= new_cplx;
      dir_q  <= ctrl_word[DIR_BIT];
    end
  end

  su_extract u_ext (.word(word_q), .idx(idx_q), .wid(wid_q), .sample(out_sample));

  assign out_is_q = iq_q;
  assign out_dir  = dir_q;

  // R9: a disabled cycle leaves nothing to present on the next one
  a_r9_disable_flush: assert property (@(posedge clk) disable iff (!srst_n)
    !en |=> !out_valid);

  // R10: a stalled sample stays put while the block remains enabled
  a_r10_stall_stable: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) ##1 en |-> out_valid && $stable(out_sample) && $stable(out_is_q));

  // R8: an emitted I part of a complex stream is followed by a Q part
  a_r8_iq_toggle: assert property (@(posedge clk) disable iff (!srst_n)
    out_fire && cplx_q && !iq_q && !in_fire |=> iq_q);

  // R8: real words never carry the Q flag
  a_r8_real_is_i: assert property (@(posedge clk) disable iff (!srst_n)
    full_q && !cplx_q |-> !iq_q);

  // R3: the sample index never passes the last slot of the captured width
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!srst_n)
    full_q |-> idx_q <= su_last_index(wid_q));

  // R11: a partly drained word keeps its data and format
  a_r11_fmt_hold: assert property (@(posedge clk) disable iff (!srst_n)
    full_q && en && !at_last |=> $stable(wid_q) && $stable(word_q));
endmodule

// File: tb/sample_unpacker_tb.sv
module sample_unpacker_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ctrl_word;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_sample;
  logic        out_is_q;
  logic        out_dir;

  sample_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
    .out_is_q(out_is_q), .out_dir(out_dir)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [15:0] smp [0:63];
  logic        qs  [0:63];
  logic        dirs[0:63];
  int          n;

  typedef struct packed {
    logic [3:0]  fmt;
    logic [31:0] word;
    logic [5:0]  cnt;
    logic [4:0]  k;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 32'h8001_1234, 6'd2,  5'd0,  16'h1234},  // R3 R4 16-bit low
    '{4'h0, 32'h8001_1234, 6'd2,  5'd1,  16'h8001},  // R4 16-bit high
    '{4'h1, 32'h0403_02F1, 6'd4,  5'd0,  16'hF100},  // R5 8-bit negative
    '{4'h1, 32'h8877_6655, 6'd4,  5'd3,  16'h8800},  // R4 R5 top byte
    '{4'h2, 32'h7654_321A, 6'd8,  5'd0,  16'hA000},  // R5 4-bit
    '{4'h2, 32'h7654_321A, 6'd8,  5'd7,  16'h7000},  // R4 top nibble
    '{4'h3, 32'h0000_0002, 6'd32, 5'd0,  16'h8001},  // R6 zero bit
    '{4'h3, 32'h0000_0002, 6'd32, 5'd1,  16'h7FFF},  // R6 one bit
    '{4'h3, 32'h8000_0000, 6'd32, 5'd31, 16'h7FFF},  // R4 R6 msb
    '{4'h4, 32'hABCD_1234, 6'd1,  5'd0,  16'hABCD},  // R7
    '{4'h5, 32'h5555_AAAA, 6'd2,  5'd1,  16'h5555},  // R3 reserved
    '{4'h7, 32'h0001_0002, 6'd2,  5'd0,  16'h0002}   // R3 reserved
  };

  function automatic logic [31:0] mk(input logic en, input logic dir,
                                     input logic [3:0] f_acq, input logic [3:0] f_ply);
    return {16'h0, f_ply, f_acq, 6'h0, dir, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    n = 0;
    while (out_valid && n < 40) begin
      smp[n]  = out_sample;
      qs[n]   = out_is_q;
      dirs[n] = out_dir;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctrl_word = mk(1'b1, 1'b0, 4'h0, 4'h0);
    in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", out_valid, 0);
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", out_valid, 0);

    // table walk: real formats, R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      ctrl_word = mk(1'b1, 1'b0, VECS[i].fmt, 4'h0);
      push(VECS[i].word);
      drain();
      chk("R3 sample count", n, VECS[i].cnt);
      chk("R4 sample value", smp[VECS[i].k], VECS[i].exp);
      for (int j = 0; j < n; j++) chk("R8 real no Q", qs[j], 0);
    end

    // R2: direction bit picks the field
    ctrl_word = mk(1'b1, 1'b0, 4'h1, 4'h4);
    push(32'hCAFE_0011); drain();
    chk("R2 acq field count", n, 4);
    chk("R2 acq dir", dirs[0], 0);
    ctrl_word = mk(1'b1, 1'b1, 4'h1, 4'h4);
    push(32'hCAFE_0011); drain();
    chk("R2 play field count", n, 1);
    chk("R2 play sample", smp[0], 16'hCAFE);
    chk("R2 play dir", dirs[0], 1);

    // R8: complex 16-bit inside one word, 32-bit across words, then real
    ctrl_word = mk(1'b1, 1'b0, 4'h8, 4'h0);
    push(32'h2222_1111); drain();
    chk("R8 c16 first I", qs[0], 0);
    chk("R8 c16 then Q", qs[1], 1);
    chk("R8 c16 Q value", smp[1], 16'h2222);
    ctrl_word = mk(1'b1, 1'b0, 4'hC, 4'h0);
    push(32'h1111_0000); drain();
    chk("R8 c32 word0 I", qs[0], 0);
    push(32'h2222_0000); drain();
    chk("R8 c32 word1 Q", qs[0], 1);
    chk("R7 c32 value", smp[0], 16'h2222);
    ctrl_word = mk(1'b1, 1'b0, 4'h0, 4'h0);
    push(32'h0002_0001); drain();
    chk("R8 real after complex", qs[0] | qs[1], 0);

    // R10: stall holds sample and blocks input
    out_ready = 1'b0;
    push(32'h2222_1111);
    chk("R10 stall valid", out_valid, 1);
    chk("R10 stall in_ready", in_ready, 0);
    repeat (3) @(negedge clk);
    chk("R10 stall held sample", out_sample, 16'h1111);
    chk("R10 stall still blocked", in_ready, 0);
    drain();
    chk("R10 stall drained count", n, 2);

    // R10: back-to-back accept on last sample
    ctrl_word = mk(1'b1, 1'b0, 4'h4, 4'h0);
    out_ready = 1'b1;
    push(32'h7777_0000);
    chk("R10 ready on last sample", in_ready, 1);
    drain();

    // R11: format change after accept does not affect held word
    ctrl_word = mk(1'b1, 1'b0, 4'h1, 4'h0);
    out_ready = 1'b0;
    push(32'h4433_2211);
    ctrl_word = mk(1'b1, 1'b0, 4'h4, 4'h0);
    @(negedge clk);
    drain();
    chk("R11 count kept", n, 4);
    chk("R11 last byte", smp[3], 16'h4400);

    // R9: disable mid-pair discards word and resets phase
    ctrl_word = mk(1'b1, 1'b0, 4'h8, 4'h0);
    out_ready = 1'b0;
    push(32'hBBBB_AAAA);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 mid-pair Q", out_is_q, 1);
    ctrl_word = mk(1'b0, 1'b0, 4'h8, 4'h0);
    in_valid = 1'b1; in_data = 32'h9999_9999;
    #1;
    chk("R9 disabled no valid", out_valid, 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R9 disabled no ready", in_ready, 0);
    end
    in_valid = 1'b0;
    ctrl_word = mk(1'b1, 1'b0, 4'h8, 4'h0);
    @(negedge clk);
    chk("R9 word discarded", out_valid, 0);
    out_ready = 1'b1;
    push(32'h4444_3333); drain();
    chk("R9 phase reset to I", qs[0], 0);
    chk("R9 fresh sample", smp[0], 16'h3333);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule